// File: doc/BRIEF.md
# Iteration-Counted Stimulus Replay Source

This block feeds the input of a unit under test with a fixed stimulus pattern held on chip. It replays the pattern beat by beat on a 128-bit AXI4-Stream master. Each beat packs four 32-bit samples. One full pass of the pattern is one iteration of 122880 samples, which is 30720 beats. At the end of a pass the read address returns to zero with no idle cycle. When the sink is always ready, the source keeps the link busy on every cycle, which leaves ample margin over a 98.3% sustained-rate target.

Software controls the block through a small register port with single-cycle writes and reads that return one cycle later. A run bit starts and stops the replay. Starting a new run clears the iteration count and begins again at beat zero. Stopping takes effect only on a beat boundary. The readable count of completed passes lets software stop after an exact number of samples. The count saturates at its maximum value. A one-cycle pulse marks the acceptance of the first beat of each run. It serves as the time reference for latency measurement downstream.

Top module: `stim_replay_top`

## Requirements
- R1: After reset, m_tvalid_o and run_start_o are low, and both the control register (offset 0x0) and the count register (offset 0x4) read 0.
- R2: Beat a of an iteration carries, in lane k (lane 0 at bits 31:0, lane k at bits 32k+31:32k), the value (4a+k) XOR 32'h5A5A_0000.
- R3: After the last beat of an iteration (beat ITER_SAMPLES/4-1), the next beat presented is beat 0.
- R4: While running and with m_tready_i high, m_tvalid_o is high on every cycle from the second cycle after the start write, including across the iteration boundary.
- R5: While m_tvalid_o is high and m_tready_i is low, m_tvalid_o stays high and m_tdata_o holds its value.
- R6: Writing 1 to bit 0 of offset 0x0 while stopped starts a run from beat 0 and clears the count. Writing 1 while running has no effect. Bit 0 of the control register reads back the run state.
- R7: Writing 0 to bit 0 of offset 0x0 stops the run. A beat already presented is held until it is accepted, and no new beat follows it.
- R8: The count at offset 0x4 increases by one on each acceptance of the last beat of an iteration. A read issued in one cycle returns its data with reg_rd_valid_o in the next cycle.
- R9: The count saturates at 2^CNT_W-1 and does not wrap.
- R10: run_start_o pulses for one cycle, in the cycle after the first beat of a run is accepted, and at no other time.
- R11: If a start write falls in the same cycle as acceptance of a last beat, the count reads 0. A beat left over from the previous run neither counts nor pulses run_start_o.
- R12: Reads of any offset other than 0x0 and 0x4 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data and register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_wr_addr_i | input | ADDR_W | Register write byte offset |
| reg_wr_data_i | input | 32 | Register write data |
| reg_rd_en_i | input | 1 | Register read strobe |
| reg_rd_addr_i | input | ADDR_W | Register read byte offset |
| reg_rd_data_o | output | 32 | Read data, one cycle after the strobe |
| reg_rd_valid_o | output | 1 | Read data valid |
| m_tvalid_o | output | 1 | Stream valid |
| m_tready_i | input | 1 | Stream ready from the sink |
| m_tdata_o | output | DATA_W | Stream data, four samples per beat |
| run_start_o | output | 1 | Pulse after the first beat of a run is accepted |

## Verification
Two events can land in the same cycle: a restart write that clears the iteration count, and acceptance of the final beat of an iteration, which would raise the count. The bench provokes this case deterministically. With the sink ready, it waits until the presented beat is the last of an iteration. It then drops ready and writes stop, so that this beat stays parked. On the next cycle it raises ready and writes start together. The outcome is judged by reading the count back as 0. The per-cycle reference model also confirms that the parked beat raised no pulse and that the stream resumed at beat 0 with exactly one pulse.

// File: rtl/stim_pkg.sv
package stim_pkg;
  localparam int unsigned REG_W = 32;
  localparam logic [31:0] STIM_SEED = 32'h5A5A_0000;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_ITER = 8'h04;
endpackage

// File: rtl/stim_rom.sv
module stim_rom #(
  parameter int unsigned SAMP_W = 32,
  parameter int unsigned LANES  = 4,
  parameter int unsigned BA_W   = 15
) (
  input  logic [BA_W-1:0]         addr_i,
  output logic [SAMP_W*LANES-1:0] data_o
);
  import stim_pkg::*;
  // contents are a fixed function of sample index
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [31:0] idx;
    assign idx = 32'(addr_i) * LANES + l;
    assign data_o[l*SAMP_W +: SAMP_W] = SAMP_W'(idx) ^ SAMP_W'(STIM_SEED);
  end
endmodule

// File: rtl/stim_seq.sv
module stim_seq #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned BEATS  = 30720,
  parameter int unsigned BA_W   = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              tready_i,
  output logic              tvalid_o,
  output logic [DATA_W-1:0] tdata_o,
  output logic [BA_W-1:0]   rom_addr_o,
  input  logic [DATA_W-1:0] rom_data_i,
  output logic              run_o,
  output logic              iter_done_o,
  output logic              first_acc_o
);
  localparam logic [BA_W-1:0] LAST = BA_W'(BEATS - 1);

  logic            run_q, first_pend_q, vld_q, first_q, last_q, pulse_q;
  logic [BA_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic hs, load;

  assign hs   = vld_q & tready_i;
  assign load = run_q & (~vld_q | tready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q        <= 1'b0;
      first_pend_q <= 1'b0;
      vld_q        <= 1'b0;
      first_q      <= 1'b0;
      last_q       <= 1'b0;
      addr_q       <= '0;
      data_q       <= '0;
      pulse_q      <= 1'b0;
    end else begin
      pulse_q <= hs & first_q;
      if (start_i) begin
        run_q        <= 1'b1;
        addr_q       <= '0;
        first_pend_q <= 1'b1;
        // a beat parked from the old run loses its tags
        first_q      <= 1'b0;
        last_q       <= 1'b0;
        if (hs) vld_q <= 1'b0;
      end else begin
        if (stop_i) run_q <= 1'b0;
        if (load) begin
          vld_q        <= 1'b1;
          data_q       <= rom_data_i;
          first_q      <= first_pend_q;
          last_q       <= (addr_q == LAST);
          addr_q       <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
          first_pend_q <= 1'b0;
        end else if (hs) begin
          vld_q <= 1'b0;
        end
      end
    end
  end

  assign tvalid_o    = vld_q;
  assign tdata_o     = data_q;
  assign rom_addr_o  = addr_q;
  assign run_o       = run_q;
  assign iter_done_o = hs & last_q;
  assign first_acc_o = pulse_q;
endmodule

// File: rtl/stim_regs.sv
module stim_regs #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic              rd_valid_o,
  input  logic              run_i,
  input  logic              iter_done_i,
  output logic              start_o,
  output logic              stop_o,
  output logic [CNT_W-1:0]  iter_cnt_o
);
  import stim_pkg::*;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             ctrl_wr;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      rd_q;
  logic             rdv_q;

  assign ctrl_wr = wr_en_i & (wr_addr_i == ADDR_W'(OFS_CTRL));
  assign start_o = ctrl_wr & wr_data_i[0] & ~run_i;
  assign stop_o  = ctrl_wr & ~wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_o) begin
      cnt_q <= '0;
    end else if (iter_done_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      rdv_q <= 1'b0;
    end else begin
      rdv_q <= rd_en_i;
      if (rd_en_i) begin
        if (rd_addr_i == ADDR_W'(OFS_CTRL))      rd_q <= {31'd0, run_i};
        else if (rd_addr_i == ADDR_W'(OFS_ITER)) rd_q <= 32'(cnt_q);
        else                                     rd_q <= '0;
      end
    end
  end

  assign rd_data_o  = rd_q;
  assign rd_valid_o = rdv_q;
  assign iter_cnt_o = cnt_q;
endmodule

// File: rtl/stim_replay_top.sv
module stim_replay_top #(
  parameter int unsigned DATA_W       = 128,
  parameter int unsigned SAMP_W       = 32,
  parameter int unsigned ITER_SAMPLES = 122880,
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned ADDR_W       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_en_i,
  input  logic [ADDR_W-1:0] reg_wr_addr_i,
  input  logic [31:0]       reg_wr_data_i,
  input  logic              reg_rd_en_i,
  input  logic [ADDR_W-1:0] reg_rd_addr_i,
  output logic [31:0]       reg_rd_data_o,
  output logic              reg_rd_valid_o,
  output logic              m_tvalid_o,
  input  logic              m_tready_i,
  output logic [DATA_W-1:0] m_tdata_o,
  output logic              run_start_o
);
  localparam int unsigned LANES = DATA_W / SAMP_W;
  localparam int unsigned BEATS = ITER_SAMPLES / LANES;
  localparam int unsigned BA_W  = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic              start_w, stop_w, run_w, iter_done_w;
  logic [BA_W-1:0]   rom_addr_w;
  logic [DATA_W-1:0] rom_data_w;
  logic [CNT_W-1:0]  iter_cnt_w;

  stim_rom #(.SAMP_W(SAMP_W), .LANES(LANES), .BA_W(BA_W)) u_rom (
    .addr_i(rom_addr_w),
    .data_o(rom_data_w)
  );

  stim_seq #(.DATA_W(DATA_W), .BEATS(BEATS), .BA_W(BA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_w),
    .stop_i     (stop_w),
    .tready_i   (m_tready_i),
    .tvalid_o   (m_tvalid_o),
    .tdata_o    (m_tdata_o),
    .rom_addr_o (rom_addr_w),
    .rom_data_i (rom_data_w),
    .run_o      (run_w),
    .iter_done_o(iter_done_w),
    .first_acc_o(run_start_o)
  );

  stim_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (reg_wr_en_i),
    .wr_addr_i  (reg_wr_addr_i),
    .wr_data_i  (reg_wr_data_i),
    .rd_en_i    (reg_rd_en_i),
    .rd_addr_i  (reg_rd_addr_i),
    .rd_data_o  (reg_rd_data_o),
    .rd_valid_o (reg_rd_valid_o),
    .run_i      (run_w),
    .iter_done_i(iter_done_w),
    .start_o    (start_w),
    .stop_o     (stop_w),
    .iter_cnt_o (iter_cnt_w)
  );
endmodule

// File: rtl/stim_replay_chk.sv
module stim_replay_chk #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tvalid_i,
  input logic              tready_i,
  input logic [DATA_W-1:0] tdata_i,
  input logic              run_i,
  input logic              start_i,
  input logic [CNT_W-1:0]  iter_cnt_i,
  input logic              pulse_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tvalid_i && !tready_i |=> tvalid_i && $stable(tdata_i));

  p_no_bubble_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && (!tvalid_i || tready_i) |=> tvalid_i);

  p_drained_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !tvalid_i |=> !tvalid_i);

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> iter_cnt_i == '0);

  p_monotonic_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> iter_cnt_i >= $past(iter_cnt_i));

  p_saturate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_cnt_i == CNT_MAX && !start_i |=> iter_cnt_i == CNT_MAX);

  p_pulse_once_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> !pulse_i);
endmodule

bind stim_replay_top stim_replay_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tvalid_i  (m_tvalid_o),
  .tready_i  (m_tready_i),
  .tdata_i   (m_tdata_o),
  .run_i     (run_w),
  .start_i   (start_w),
  .iter_cnt_i(iter_cnt_w),
  .pulse_i   (run_start_o)
);

// File: tb/tb_stim_replay_top.sv
module tb_stim_replay_top;
  localparam int DATA_W = 128;
  localparam int ITERS  = 64;
  localparam int BEATS  = ITERS / 4;
  localparam int CNT_W  = 3;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, tready = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic rd_valid, tvalid, pulse;
  logic [DATA_W-1:0] tdata;

  int checks = 0, failures = 0, cycles = 0, pulses = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stim_replay_top #(.ITER_SAMPLES(ITERS), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_en_i(wr_en), .reg_wr_addr_i(wr_addr), .reg_wr_data_i(wr_data),
    .reg_rd_en_i(rd_en), .reg_rd_addr_i(rd_addr),
    .reg_rd_data_o(rd_data), .reg_rd_valid_o(rd_valid),
    .m_tvalid_o(tvalid), .m_tready_i(tready), .m_tdata_o(tdata),
    .run_start_o(pulse)
  );

  function automatic logic [DATA_W-1:0] beat(int a);
    logic [DATA_W-1:0] b;
    for (int k = 0; k < 4; k++) b[k*32 +: 32] = 32'(a*4 + k) ^ 32'h5A5A_0000;
    return b;
  endfunction

  // behavioural reference model
  bit m_run, m_vld, m_first, m_last, m_pf, m_pulse, m_rdv;
  int m_idx, m_cnt, m_beat;
  logic [31:0] m_rdd;

  always @(posedge clk) if (rst_n) begin
    bit hs, st, sp, ld;
    hs = m_vld && tready;
    st = wr_en && wr_addr == 0 && wr_data[0] && !m_run;
    sp = wr_en && wr_addr == 0 && !wr_data[0];
    m_rdv = rd_en;
    if (rd_en) m_rdd = (rd_addr == 0) ? 32'(m_run) : (rd_addr == 4) ? 32'(m_cnt) : 0;
    m_pulse = hs && m_first;
    if (st) m_cnt = 0;
    else if (hs && m_last && m_cnt < CMAX) m_cnt++;
    ld = m_run && (!m_vld || tready);
    if (st) begin
      m_run = 1; m_idx = 0; m_pf = 1; m_first = 0; m_last = 0;
      if (hs) m_vld = 0;
    end else begin
      if (sp) m_run = 0;
      if (ld) begin
        m_vld = 1; m_beat = m_idx; m_first = m_pf; m_pf = 0;
        m_last = (m_idx == BEATS-1);
        m_idx = (m_idx + 1) % BEATS;
      end else if (hs) m_vld = 0;
    end
  end

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    cycles++;
    if (pulse) pulses++;
    chk(tvalid == m_vld, "R4/R5/R7 tvalid", 128'(tvalid), 128'(m_vld));
    if (m_vld) chk(tdata == beat(m_beat), "R2/R3 tdata", tdata, beat(m_beat));
    chk(pulse == m_pulse, "R10 pulse", 128'(pulse), 128'(m_pulse));
    chk(rd_valid == m_rdv, "R8 rd_valid", 128'(rd_valid), 128'(m_rdv));
    if (m_rdv) chk(rd_data == m_rdd, "R8/R12 rd_data", 128'(rd_data), 128'(m_rdd));
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; v = rd_data;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, c0;
    logic [DATA_W-1:0] held;
    int p0;
    repeat (3) @(negedge clk);
    chk(tvalid == 0 && pulse == 0, "R1 outputs", 128'({tvalid, pulse}), 0);
    rst_n = 1;
    @(negedge clk);
    rd(0, v); chk(v == 0, "R1 ctrl", 128'(v), 0);
    rd(4, v); chk(v == 0, "R1 count", 128'(v), 0);
    rd(8, v); chk(v == 0, "R12 unmapped", 128'(v), 0);
    rd(12, v); chk(v == 0, "R12 unmapped", 128'(v), 0);

    // free-running replay across iteration boundaries
    tready = 1;
    wr(0, 1);
    repeat (3 * BEATS + 4) @(negedge clk);
    rd(4, v); chk(v == 3, "R8 count after 3 passes", 128'(v), 3);
    chk(pulses == 1, "R10 one pulse per run", 128'(pulses), 1);
    rd(0, v); chk(v == 1, "R6 ctrl readback", 128'(v), 1);
    rd(4, c0);
    wr(0, 1);
    rd(4, v); chk(v >= c0 && v != 0, "R6 start while running ignored", 128'(v), 128'(c0));

    // random backpressure
    for (int i = 0; i < 300; i++) begin
      tready = ($urandom % 3) != 0;
      @(negedge clk);
    end

    // stop with a beat parked
    tready = 0;
    @(negedge clk);
    wr(0, 0);
    held = tdata;
    repeat (5) @(negedge clk);
    chk(tvalid == 1 && tdata == held, "R7 parked beat held", tdata, held);
    tready = 1;
    @(negedge clk);
    repeat (10) @(negedge clk);
    chk(tvalid == 0, "R7 no beat after stop", 128'(tvalid), 0);
    rd(0, v); chk(v == 0, "R7 ctrl stopped", 128'(v), 0);

    // restart, then saturate
    p0 = pulses;
    wr(0, 1);
    rd(4, v); chk(v == 0, "R6 restart clears count", 128'(v), 0);
    repeat (10 * BEATS) @(negedge clk);
    chk(pulses == p0 + 1, "R10 pulse on restart", 128'(pulses - p0), 1);
    rd(4, v); chk(v == CMAX, "R9 saturated count", 128'(v), CMAX);

    // restart coincident with last-beat acceptance
    while (!(m_vld && m_last)) @(negedge clk);
    tready = 0;
    wr(0, 0);
    tready = 1;
    p0 = pulses;
    wr(0, 1);
    rd(4, v); chk(v == 0, "R11 clear wins over increment", 128'(v), 0);
    repeat (BEATS / 2) @(negedge clk);
    chk(pulses == p0 + 1, "R11 single pulse for new run", 128'(pulses - p0), 1);
    rd(4, v); chk(v == 0, "R11 leftover not counted", 128'(v), 0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule